// File: doc/BRIEF.md
# Fractional M/N:D Root Clock Generator

This block builds a derived clock from one of several source clocks. All timing runs on a single fast system clock: each source is given as a one-cycle pulse on every edge, rising or falling, of that source. The selected source first passes through a pre-divider that counts source edges, so it can divide by half-integer ratios. The result then either goes straight to the output or drives an M/N:D counter, which gives a fractional average rate of M/N and a high time set by D.

Software programs a set of shadow registers at any time. The new values take effect only when software sets the update bit. The block copies the shadow values into its active state at the next output period boundary and clears the bit once the new setting is live. A separate branch-enable bit gates the output. The gate opens or closes only on period boundaries, so the output never carries a partial period.

Top module: `mnd_clkgen`

## Requirements
- R1: Registers are selected by a 3-bit address: 0 holds M, 1 holds the inverse of (N minus M), 2 holds the inverse of D, 3 holds the configuration, 4 is the command, and 5 is the branch control. Each reads back what was written, within its implemented bits. All of them read 0 after reset.
- R2: Configuration bits [4:0] form the pre-divide field f. The value 0 divides by 1. Any other value divides by (f+1)/2, which gives a period of f+1 source edges. Bypass gives a period of 2 source edges. The pre-divided clock is high for the first ceil(L/2) edges of each L-edge period, so f=20 gives a 21-edge period that is high for 11 edges.
- R3: Configuration bits [10:8] pick which source edge input drives the pre-divider.
- R4: Configuration bits [13:12] set the mode. Value 0 sends the pre-divided clock to the output. Any other value, with 2 as the normal dual-edge setting, uses the counter. On each pre-divided period the counter adds M modulo N. The output is high while the counter is below D, and the counter wrap marks the output period boundary. The average period is N/M pre-divided periods.
- R5: Writing 1 to command bit 0 sets the update bit. The shadow values become active on the first period boundary after the bit is set, and the bit reads 0 from the second cycle after that boundary. Writing 0 to the command register has no effect.
- R6: Shadow register writes made without an update request leave the output period and high time unchanged.
- R7: Branch-control bit 0 is sampled only at period boundaries. While the sampled value is 0 the output is held low. After it is set, the output resumes with whole periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEdge | input | NUM_SRC | Per-source edge pulses, one per source clock edge |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | DATA_W | Combinational register read data |
| clkOut | output | 1 | Gated generated clock level |

## Verification
The output level is registered, so it follows the pre-divider and counter state by one fast cycle. A gate change shows at the output one cycle after the boundary that samples it. The update bit reads 1 on the cycle after the write that sets it, and reads 0 two cycles after the boundary that applies the new setting. The bench reads the command bit right after its write, then polls it with a bounded limit. Period and high-time checks start only after a fresh rising edge of the output and span several whole periods, so the fixed apply and gate latency never falls inside a measured window.

// File: rtl/mndgen_pkg.sv
package mndgen_pkg;
  localparam int ADDR_W   = 3;
  localparam int PRE_LSB  = 0;
  localparam int PRE_W    = 5;
  localparam int SRC_LSB  = 8;
  localparam int SRC_W    = 3;
  localparam int MODE_LSB = 12;
  localparam int MODE_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_M      = 3'd0,
    REG_NINV   = 3'd1,
    REG_DINV   = 3'd2,
    REG_CFG    = 3'd3,
    REG_CMD    = 3'd4,
    REG_BRANCH = 3'd5
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic apply;
    logic gateOn;
  } ctlStrobe_t;
endpackage

// File: rtl/mndgen_ctrl.sv
module mndgen_ctrl
  import mndgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              boundary,
  output logic [CNT_W-1:0]  shM,
  output logic [CNT_W-1:0]  shNInv,
  output logic [CNT_W-1:0]  shDInv,
  output logic [PRE_W-1:0]  shPre,
  output logic [SRC_W-1:0]  shSrc,
  output logic [MODE_W-1:0] shMode,
  output ctlStrobe_t        ctl
);
  logic updPending;
  logic clrPend;
  logic branchEn;
  logic gateOn;
  logic apply;
  logic setReq;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign apply  = updPending && !clrPend && boundary;
  assign setReq = wrEn && (wrAddr == REG_CMD) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shM        <= '0;
      shNInv     <= '0;
      shDInv     <= '0;
      shPre      <= '0;
      shSrc      <= '0;
      shMode     <= '0;
      branchEn   <= 1'b0;
      updPending <= 1'b0;
      clrPend    <= 1'b0;
      gateOn     <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          REG_M:      shM    <= wrData[CNT_W-1:0];
          REG_NINV:   shNInv <= wrData[CNT_W-1:0];
          REG_DINV:   shDInv <= wrData[CNT_W-1:0];
          REG_CFG: begin
            shPre  <= wrData[PRE_LSB +: PRE_W];
            shSrc  <= wrData[SRC_LSB +: SRC_W];
            shMode <= wrData[MODE_LSB +: MODE_W];
          end
          REG_BRANCH: branchEn <= wrData[0];
          default: ;
        endcase
      end
      clrPend <= apply;
      if (setReq) updPending <= 1'b1;
      else if (clrPend) updPending <= 1'b0;
      if (boundary) gateOn <= branchEn;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_M:      rdData[CNT_W-1:0] = shM;
      REG_NINV:   rdData[CNT_W-1:0] = shNInv;
      REG_DINV:   rdData[CNT_W-1:0] = shDInv;
      REG_CFG: begin
        rdData[PRE_LSB +: PRE_W]   = shPre;
        rdData[SRC_LSB +: SRC_W]   = shSrc;
        rdData[MODE_LSB +: MODE_W] = shMode;
      end
      REG_CMD:    rdData[0] = updPending;
      REG_BRANCH: rdData[0] = branchEn;
      default: ;
    endcase
  end

  assign ctl.apply  = apply;
  assign ctl.gateOn = gateOn;
endmodule

// File: rtl/mndgen_dp.sv
module mndgen_dp
  import mndgen_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEdge,
  input  logic [CNT_W-1:0]   shM,
  input  logic [CNT_W-1:0]   shNInv,
  input  logic [CNT_W-1:0]   shDInv,
  input  logic [PRE_W-1:0]   shPre,
  input  logic [SRC_W-1:0]   shSrc,
  input  logic [MODE_W-1:0]  shMode,
  input  ctlStrobe_t         ctl,
  output logic               boundary,
  output logic               clkOut
);
  localparam int LEN_W = PRE_W + 1;

  typedef struct packed {
    logic [CNT_W-1:0]  m;
    logic [CNT_W-1:0]  n;
    logic [CNT_W-1:0]  d;
    logic [PRE_W-1:0]  pre;
    logic [SRC_W-1:0]  src;
    logic [MODE_W-1:0] mode;
  } actCfg_t;

  actCfg_t          act;
  logic [LEN_W-1:0] ePos;
  logic [LEN_W-1:0] preLen;
  logic [LEN_W-1:0] preHalf;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nextCnt;
  logic             selEdge;
  logic             preTick;
  logic             wrap;
  logic             levelNext;

  // source select: one compare per source
  always_comb begin
    selEdge = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act.src == SRC_W'(i)) selEdge = srcEdge[i];
    end
  end

  // period length in source edges; bypass counts as ratio 1
  assign preLen  = (act.pre == '0) ? LEN_W'(2) : ({1'b0, act.pre} + LEN_W'(1));
  assign preHalf = (preLen + LEN_W'(1)) >> 1;
  assign preTick = selEdge && (ePos == preLen - LEN_W'(1));

  // modular accumulator
  assign sum      = {1'b0, cnt} + {1'b0, act.m};
  assign wrap     = sum >= {1'b0, act.n};
  assign nextCnt  = wrap ? (sum[CNT_W-1:0] - act.n) : sum[CNT_W-1:0];
  assign boundary = preTick && ((act.mode == '0) || wrap);

  assign levelNext = (act.mode == '0) ? (ePos < preHalf) : (cnt < act.d);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act    <= '0;
      ePos   <= '0;
      cnt    <= '0;
      clkOut <= 1'b0;
    end else begin
      if (ctl.apply) begin
        act.m    <= shM;
        act.n    <= shM + ~shNInv;
        act.d    <= ~shDInv;
        act.pre  <= shPre;
        act.src  <= shSrc;
        act.mode <= shMode;
        ePos     <= '0;
        cnt      <= '0;
      end else begin
        if (selEdge) ePos <= preTick ? '0 : (ePos + LEN_W'(1));
        if (preTick) cnt <= nextCnt;
      end
      clkOut <= ctl.gateOn && levelNext;
    end
  end
endmodule

// File: rtl/mnd_clkgen.sv
module mnd_clkgen
  import mndgen_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEdge,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [2:0]         rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               clkOut
);
  ctlStrobe_t        ctl;
  logic              boundary;
  logic [CNT_W-1:0]  shM;
  logic [CNT_W-1:0]  shNInv;
  logic [CNT_W-1:0]  shDInv;
  logic [PRE_W-1:0]  shPre;
  logic [SRC_W-1:0]  shSrc;
  logic [MODE_W-1:0] shMode;

  mndgen_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ctrlI (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .boundary(boundary),
    .shM(shM), .shNInv(shNInv), .shDInv(shDInv),
    .shPre(shPre), .shSrc(shSrc), .shMode(shMode),
    .ctl(ctl)
  );

  mndgen_dp #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) dpI (
    .clk(clk), .rstN(rstN), .srcEdge(srcEdge),
    .shM(shM), .shNInv(shNInv), .shDInv(shDInv),
    .shPre(shPre), .shSrc(shSrc), .shMode(shMode),
    .ctl(ctl), .boundary(boundary), .clkOut(clkOut)
  );
endmodule

// File: rtl/mnd_clkgen_chk.sv
module mnd_clkgen_chk #(
  parameter int CFG_W = 34,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             applyStrobe,
  input logic             boundary,
  input logic             updPending,
  input logic             gateOn,
  input logic             clkOut,
  input logic [LEN_W-1:0] ePos,
  input logic [LEN_W-1:0] preLen,
  input logic [CFG_W-1:0] actCfg
);
  assert_prediv_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ePos < preLen);

  assert_apply_on_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    applyStrobe |-> boundary);

  assert_upd_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updPending) |-> $past(applyStrobe, 2));

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actCfg) |-> $past(applyStrobe));

  assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |=> !clkOut);

  assert_gate_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateOn) |-> $past(boundary));
endmodule

bind mnd_clkgen mnd_clkgen_chk #(
  .CFG_W(3 * CNT_W + mndgen_pkg::PRE_W + mndgen_pkg::SRC_W + mndgen_pkg::MODE_W),
  .LEN_W(mndgen_pkg::PRE_W + 1)
) chkI (
  .clk(clk),
  .rstN(rstN),
  .applyStrobe(ctl.apply),
  .boundary(boundary),
  .updPending(ctrlI.updPending),
  .gateOn(ctl.gateOn),
  .clkOut(clkOut),
  .ePos(dpI.ePos),
  .preLen(dpI.preLen),
  .actCfg(dpI.act)
);

// File: tb/mnd_clkgen_tb_top.sv
module mnd_clkgen_tb_top;
  localparam int ADDR_M = 0, ADDR_N = 1, ADDR_D = 2, ADDR_CFG = 3, ADDR_CMD = 4, ADDR_BR = 5;

  typedef struct {
    int    nPer;
    int    cyc;
    int    high;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcToggle = 1'b0;
  logic [3:0]  srcEdge;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        clkOut;

  int checkCnt = 0;
  int failCnt  = 0;
  expItem_t expQ[$];
  bit monBusy = 1'b0;

  always #10 clk = ~clk;
  assign srcEdge = {2'b00, srcToggle, 1'b1};

  initial forever begin
    @(negedge clk);
    srcToggle = ~srcToggle;
  end

  mnd_clkgen dut_i (
    .clk(clk), .rstN(rstN), .srcEdge(srcEdge),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .clkOut(clkOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    rdAddr = 3'(addr);
    #1;
    data = rdData;
  endtask

  task automatic requestUpdate(input string tag);
    logic [31:0] v;
    int waited;
    regWrite(ADDR_CMD, 32'h1);
    regRead(ADDR_CMD, v);
    check(v[0] == 1'b1, {"R5 update bit set ", tag}, int'(v[0]), 1);
    waited = 0;
    while (v[0] && waited < 200) begin
      @(negedge clk);
      regRead(ADDR_CMD, v);
      waited++;
    end
    check(v[0] == 1'b0, {"R5 update bit cleared ", tag}, int'(v[0]), 0);
  endtask

  task automatic expectOut(input int nPer, input int cyc, input int high, input string tag);
    expItem_t it;
    it.nPer = nPer; it.cyc = cyc; it.high = high; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    wait (!monBusy);
  endtask

  // monitor: aligns to a rising edge, then measures whole periods
  initial forever begin
    expItem_t it;
    logic last;
    int cyc, high, rises;
    wait (expQ.size() > 0);
    monBusy = 1'b1;
    it = expQ.pop_front();
    @(negedge clk);
    do begin
      last = clkOut;
      @(negedge clk);
    end while (!(clkOut && !last));
    cyc = 0; high = 0; rises = 0;
    while (rises < it.nPer) begin
      if (clkOut) high++;
      cyc++;
      last = clkOut;
      @(negedge clk);
      if (clkOut && !last) rises++;
    end
    check(cyc == it.cyc, {it.tag, " cycles"}, cyc, it.cyc);
    check(high == it.high, {it.tag, " high"}, high, it.high);
    monBusy = 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int highs;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      regRead(a, v);
      check(v == 32'h0, "R1 reset register value", int'(v), 0);
    end
    check(clkOut == 1'b0, "R7 output low after reset", int'(clkOut), 0);

    // R7 gate closed keeps output low
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clkOut) highs++;
    end
    check(highs == 0, "R7 output low while branch off", highs, 0);

    regWrite(ADDR_BR, 32'h1);
    regRead(ADDR_BR, v);
    check(v == 32'h1, "R1 branch readback", int'(v), 1);
    expectOut(4, 8, 4, "R7 resume / R2 bypass divide");

    // R2 half-integer 10.5: 21 edges, high 11
    regWrite(ADDR_CFG, 32'd20);
    requestUpdate("prediv 10.5");
    expectOut(3, 63, 33, "R2 divide 10.5");

    // R6 shadow changes without update
    regWrite(ADDR_CFG, 32'd2);
    regWrite(ADDR_M, 32'd7);
    regRead(ADDR_CFG, v);
    check(v == 32'd2, "R1 cfg readback", int'(v), 2);
    regRead(ADDR_M, v);
    check(v == 32'd7, "R1 M readback", int'(v), 7);
    expectOut(3, 63, 33, "R6 shadow isolated");

    // R2 divide 1.5: 3 edges, high 2
    requestUpdate("prediv 1.5");
    expectOut(4, 12, 8, "R2 divide 1.5");

    // R3 source 1 edges every other cycle: period 4, high 2
    regWrite(ADDR_CFG, 32'h100);
    requestUpdate("source 1");
    expectOut(3, 12, 6, "R3 source 1");

    // R4 M=1 N=5 D=2, mode 2
    regWrite(ADDR_M, 32'd1);
    regWrite(ADDR_N, ~32'd4);
    regWrite(ADDR_D, ~32'd2);
    regWrite(ADDR_CFG, 32'h2000);
    requestUpdate("mnd 1/5");
    expectOut(3, 30, 12, "R4 M/N:D 1/5");

    // R4 fractional M=2 N=5 D=2
    regWrite(ADDR_M, 32'd2);
    regWrite(ADDR_N, ~32'd3);
    requestUpdate("mnd 2/5");
    expectOut(4, 20, 8, "R4 fractional 2/5");

    // R4 with R2 pre-divide 10.5, M=1 N=2 D=1
    regWrite(ADDR_M, 32'd1);
    regWrite(ADDR_N, ~32'd1);
    regWrite(ADDR_D, ~32'd1);
    regWrite(ADDR_CFG, 32'h2014);
    requestUpdate("mnd over 10.5");
    expectOut(2, 84, 42, "R4 counter after 10.5 divide");
    regRead(ADDR_N, v);
    check(v == 32'hFE, "R1 N readback", int'(v), 32'hFE);

    // R7 gate off at a boundary
    regWrite(ADDR_BR, 32'h0);
    repeat (100) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (clkOut) highs++;
    end
    check(highs == 0, "R7 output held low when disabled", highs, 0);

    // R5 update completes while gated off
    regWrite(ADDR_M, 32'd1);
    regWrite(ADDR_N, ~32'd3);
    regWrite(ADDR_D, ~32'd1);
    regWrite(ADDR_CFG, 32'h2000);
    requestUpdate("while disabled");
    highs = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (clkOut) highs++;
    end
    check(highs == 0, "R7 still low after update", highs, 0);
    regWrite(ADDR_BR, 32'h1);
    expectOut(3, 24, 6, "R7 resume M/N:D 1/4");

    // R5 writing 0 does nothing; R6 pending shadow stays inactive
    regWrite(ADDR_CFG, 32'h100);
    regWrite(ADDR_CMD, 32'h0);
    regRead(ADDR_CMD, v);
    check(v == 32'h0, "R5 command write of 0", int'(v), 0);
    expectOut(3, 24, 6, "R6 no update without request");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule